// File: doc/BRIEF.md
# Machine-Cycle Sequencer with Refresh Counter

This block drives the bus timing for the front end of an 8-bit processor. It splits each instruction into machine cycles of three kinds: opcode fetch, memory read and memory write. It counts the T-states inside each cycle and shows which kind of cycle is running through fetch, read, write and refresh strobes. Every opcode fetch ends with a refresh slot. During that slot a 7-bit refresh counter is placed on the address bus, and the counter steps forward when the fetch finishes.

The sequencer reads its bytes from a memory port that returns data combinationally for the address it presents. Only a small part of decoding happens here: the sequencer detects the prefix bytes and so knows how many fetches follow. An index prefix (0xDD selects the X index, 0xFD the Y index) followed by the bit-operation prefix 0xCB starts the long indexed read-modify-write form. In that form a displacement byte arrives by a plain read, and this read falls between the second and the third fetch. The index base values and the modified result come from outside the block. A one-clock done pulse marks the last T-state of every instruction.

Top module: `mcycle_seq`

## Requirements
- R1: While reset is held, and in the first clock after it is released, the outputs are: tState = 1, m1 = 1, rdStb = 1, wrStb = 0, rfshStb = 0, done = 0, memAddr = RESET_PC (0), and rfshAddr = RFSH_INIT.
- R2: A byte other than 0xDD, 0xFD, 0xCB or 0xED, fetched as the first byte of an instruction, completes the instruction in one opcode-fetch cycle of 4 T-states.
- R3: rfshAddr changes only when an opcode-fetch cycle ends. Each such cycle adds one to its low 7 bits, so 0x7F wraps to 0x00, and bit 7 keeps its reset value.
- R4: A first byte of 0xDD, 0xFD, 0xCB or 0xED is a prefix. The byte fetched after it completes the instruction, so the instruction takes two 4-T fetch cycles and two refresh steps. The exception is 0xDD/0xFD followed by 0xCB.
- R5: 0xDD or 0xFD followed by 0xCB runs six cycles of lengths 4, 4, 3, 5, 4, 3 (23 T-states). m1 is high in cycles 1, 2 and 4 only, so the refresh counter steps three times.
- R6: The third cycle of that form is a read of the displacement byte at the address after the 0xCB byte, with rdStb high and m1 low.
- R7: Cycles 5 and 6 of that form both address X (for 0xDD) or Y (for 0xFD) plus the displacement, taken as a signed 8-bit value, modulo 2^16. Cycle 6 asserts wrStb and places rmwResult on memWrData.
- R8: In a fetch cycle, T1 and T2 assert rdStb and address the program counter. The remaining T-states assert rfshStb and put {8'h00, rfshAddr} on memAddr.
- R9: After done, opcode holds the last byte fetched in an opcode-fetch cycle. After an indexed read-modify-write, operand holds the byte read in cycle 5.
- R10: done is high for exactly the last T-state of an instruction, and the next clock shows T1 of a fresh fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| memData | input | 8 | Byte returned by memory for memAddr |
| ixVal | input | 16 | X index base value |
| iyVal | input | 16 | Y index base value |
| rmwResult | input | 8 | Modified byte to write back in cycle 6 |
| memAddr | output | 16 | Bus address |
| memWrData | output | 8 | Write data, zero outside write cycles |
| m1 | output | 1 | High during the whole of an opcode-fetch cycle |
| rdStb | output | 1 | Memory read strobe |
| wrStb | output | 1 | Memory write strobe |
| rfshStb | output | 1 | Refresh slot strobe |
| tState | output | 3 | Current T-state, counting from 1 |
| rfshAddr | output | 8 | Refresh counter |
| opcode | output | 8 | Last byte captured by a fetch cycle |
| operand | output | 8 | Byte read from the indexed location |
| done | output | 1 | Last T-state of an instruction |

## Verification
The hardest case to reach from the ports is the indexed read-modify-write form. Its fetch cycles are split by a plain read, and its address computation has to carry a negative displacement and wrap past 0xFFFF. The program therefore holds three such instructions. One uses a positive displacement from Y, one uses displacement 0xFE from X, and the last runs after the X base has been changed to 0xFFF8 so that the sum wraps to 0x0070. A second instance starts its refresh counter at 0xFE, which lets the bench see the 7-bit wrap with bit 7 set. A run of 120 plain opcodes then carries the main instance's counter past 0x7F.

// File: rtl/mcycle_pkg.sv
package mcycle_pkg;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;

  typedef enum logic [2:0] {
    ST_OP   = 3'd0,  // first opcode fetch
    ST_OP2  = 3'd1,  // fetch following a prefix
    ST_DISP = 3'd2,  // displacement read
    ST_XOP  = 3'd3,  // final opcode fetch, stretched
    ST_XRD  = 3'd4,  // indexed operand read
    ST_XWR  = 3'd5   // indexed write-back
  } step_e;

  typedef struct packed {
    cyc_e       cyc;
    logic [2:0] tNow;
    logic       lastT;
    logic       useEa;
    logic       selIy;
    logic       capDisp;
    logic       capOperand;
  } ctlStrobe_t;

  localparam logic [7:0] PFX_IX  = 8'hDD;
  localparam logic [7:0] PFX_IY  = 8'hFD;
  localparam logic [7:0] PFX_BIT = 8'hCB;
  localparam logic [7:0] PFX_EXT = 8'hED;

  function automatic logic [2:0] stepLen(step_e s);
    case (s)
      ST_DISP: return 3'd3;
      ST_XOP:  return 3'd5;
      ST_XWR:  return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic cyc_e stepCyc(step_e s);
    case (s)
      ST_DISP, ST_XRD: return CYC_READ;
      ST_XWR:          return CYC_WRITE;
      default:         return CYC_FETCH;
    endcase
  endfunction

endpackage

// File: rtl/mcycle_ctrl.sv
module mcycle_ctrl
  import mcycle_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] fetchByte,
  output ctlStrobe_t strb,
  output logic       m1,
  output logic       rdStb,
  output logic       wrStb,
  output logic       rfshStb,
  output logic       done,
  output logic [2:0] tState
);

  step_e      stepQ, stepNxt;
  logic [2:0] tCnt;
  logic       idxQ, iyQ;
  logic       lastT;
  logic       finish;
  logic       isIdx;
  cyc_e       cycNow;

  assign isIdx  = (fetchByte == PFX_IX) || (fetchByte == PFX_IY);
  assign lastT  = (tCnt == stepLen(stepQ));
  assign cycNow = stepCyc(stepQ);

  always_comb begin
    stepNxt = ST_OP;
    finish  = 1'b0;
    case (stepQ)
      ST_OP: begin
        if (isIdx || fetchByte == PFX_BIT || fetchByte == PFX_EXT) stepNxt = ST_OP2;
        else finish = 1'b1;
      end
      ST_OP2: begin
        if (idxQ && fetchByte == PFX_BIT) stepNxt = ST_DISP;
        else finish = 1'b1;
      end
      ST_DISP: stepNxt = ST_XOP;
      ST_XOP:  stepNxt = ST_XRD;
      ST_XRD:  stepNxt = ST_XWR;
      default: finish  = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ <= ST_OP;
      tCnt  <= 3'd1;
      idxQ  <= 1'b0;
      iyQ   <= 1'b0;
    end else if (lastT) begin
      stepQ <= stepNxt;
      tCnt  <= 3'd1;
      if (stepQ == ST_OP) begin
        idxQ <= isIdx;
        iyQ  <= (fetchByte == PFX_IY);
      end
    end else begin
      tCnt <= tCnt + 3'd1;
    end
  end

  always_comb begin
    strb.cyc        = cycNow;
    strb.tNow       = tCnt;
    strb.lastT      = lastT;
    strb.useEa      = (stepQ == ST_XRD) || (stepQ == ST_XWR);
    strb.selIy      = iyQ;
    strb.capDisp    = (stepQ == ST_DISP) && lastT;
    strb.capOperand = (stepQ == ST_XRD) && lastT;
  end

  assign m1      = (cycNow == CYC_FETCH);
  assign rdStb   = (m1 && tCnt <= 3'd2) || (cycNow == CYC_READ);
  assign wrStb   = (cycNow == CYC_WRITE);
  assign rfshStb = m1 && (tCnt >= 3'd3);
  assign done    = lastT && finish;
  assign tState  = tCnt;

  // R2, R5: T-state counter stays inside the longest cycle
  a_r5_t_range: assert property (@(posedge clk) disable iff (!rstN)
    (tCnt >= 3'd1) && (tCnt <= 3'd5));

  // R10: a done pulse is followed by T1 of a new first fetch
  a_r10_done_restart: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (tCnt == 3'd1) && (stepQ == ST_OP) && !done);

  // R5: the write-back cycle is entered only from the operand read
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (stepQ == ST_XWR && tCnt == 3'd1) |-> ($past(stepQ) == ST_XRD));

  // R6: displacement cycle is a plain read
  a_r6_disp_no_m1: assert property (@(posedge clk) disable iff (!rstN)
    (stepQ == ST_DISP) |-> (!m1 && rdStb && !wrStb));

  // R8: bus strobes never overlap
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdStb, wrStb, rfshStb}));

endmodule

// File: rtl/mcycle_dpath.sv
module mcycle_dpath
  import mcycle_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter logic [15:0]     RESET_PC  = 16'h0000,
  parameter logic [7:0]      RFSH_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [7:0]        memData,
  input  logic [ADDR_W-1:0] ixVal,
  input  logic [ADDR_W-1:0] iyVal,
  input  logic [7:0]        rmwResult,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic [7:0]        rfshAddr,
  output logic [7:0]        fetchByte,
  output logic [7:0]        opcode,
  output logic [7:0]        operand
);

  localparam int RFSH_W = 7;
  localparam int EXT_W  = ADDR_W - 8;

  logic [ADDR_W-1:0] pcQ;
  logic [7:0]        rfshQ;
  logic [7:0]        opQ, dispQ, operandQ;
  logic [ADDR_W-1:0] baseVal, effAddr;
  logic              capOp, rfshInc;

  assign capOp   = (strb.cyc == CYC_FETCH) && (strb.tNow == 3'd2);
  assign rfshInc = (strb.cyc == CYC_FETCH) && strb.lastT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ      <= RESET_PC[ADDR_W-1:0];
      rfshQ    <= RFSH_INIT;
      opQ      <= 8'h00;
      dispQ    <= 8'h00;
      operandQ <= 8'h00;
    end else begin
      if (capOp) begin
        opQ <= memData;
        pcQ <= pcQ + 1'b1;
      end
      if (strb.capDisp) begin
        dispQ <= memData;
        pcQ   <= pcQ + 1'b1;
      end
      if (strb.capOperand) operandQ <= memData;
      if (rfshInc) rfshQ <= {rfshQ[7], rfshQ[RFSH_W-1:0] + 1'b1};
    end
  end

  assign baseVal = strb.selIy ? iyVal : ixVal;
  assign effAddr = baseVal + {{EXT_W{dispQ[7]}}, dispQ};

  always_comb begin
    if (strb.useEa)
      memAddr = effAddr;
    else if (strb.cyc == CYC_FETCH && strb.tNow >= 3'd3)
      memAddr = {{EXT_W{1'b0}}, rfshQ};
    else
      memAddr = pcQ;
  end

  assign memWrData = (strb.cyc == CYC_WRITE) ? rmwResult : 8'h00;
  assign rfshAddr  = rfshQ;
  assign fetchByte = opQ;
  assign opcode    = opQ;
  assign operand   = operandQ;

  // R3: refresh counter moves only at the end of a fetch cycle
  a_r3_rfsh_only_m1: assert property (@(posedge clk) disable iff (!rstN)
    !((strb.cyc == CYC_FETCH) && strb.lastT) |=> $stable(rfshQ));

  // R3: top refresh bit never changes
  a_r3_bit7_held: assert property (@(posedge clk) disable iff (!rstN)
    $stable(rfshQ[7]));

  // R7: write-back reuses the address of the operand read
  a_r7_same_ea: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cyc == CYC_WRITE && strb.tNow == 3'd1) |-> $stable(dispQ));

endmodule

// File: rtl/mcycle_seq.sv
module mcycle_seq
  import mcycle_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] RESET_PC  = 16'h0000,
  parameter logic [7:0]  RFSH_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        memData,
  input  logic [ADDR_W-1:0] ixVal,
  input  logic [ADDR_W-1:0] iyVal,
  input  logic [7:0]        rmwResult,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic              m1,
  output logic              rdStb,
  output logic              wrStb,
  output logic              rfshStb,
  output logic [2:0]        tState,
  output logic [7:0]        rfshAddr,
  output logic [7:0]        opcode,
  output logic [7:0]        operand,
  output logic              done
);

  ctlStrobe_t strb;
  logic [7:0] fetchByte;

  mcycle_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .fetchByte (fetchByte),
    .strb      (strb),
    .m1        (m1),
    .rdStb     (rdStb),
    .wrStb     (wrStb),
    .rfshStb   (rfshStb),
    .done      (done),
    .tState    (tState)
  );

  mcycle_dpath #(
    .ADDR_W    (ADDR_W),
    .RESET_PC  (RESET_PC),
    .RFSH_INIT (RFSH_INIT)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .memData   (memData),
    .ixVal     (ixVal),
    .iyVal     (iyVal),
    .rmwResult (rmwResult),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .rfshAddr  (rfshAddr),
    .fetchByte (fetchByte),
    .opcode    (opcode),
    .operand   (operand)
  );

endmodule

// File: tb/mcycle_seq_tb.sv
`timescale 1ns/1ps
module mcycle_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  memData;
  logic [15:0] ixVal = 16'h0082;
  logic [15:0] iyVal = 16'h0040;
  logic [7:0]  rmwResult;
  logic [15:0] memAddr;
  logic [7:0]  memWrData;
  logic        m1, rdStb, wrStb, rfshStb, done;
  logic [2:0]  tState;
  logic [7:0]  rfshAddr, opcode, operand;

  logic [15:0] hiAddr;
  logic [7:0]  hiWrData, hiRfsh, hiOpcode, hiOperand;
  logic        hiM1, hiRd, hiWr, hiRfshStb, hiDone;
  logic [2:0]  hiT;

  logic [7:0] mem [256];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  assign memData   = mem[memAddr[7:0]];
  assign rmwResult = operand ^ 8'hFF;

  mcycle_seq dut_i (
    .clk(clk), .rstN(rstN), .memData(memData), .ixVal(ixVal), .iyVal(iyVal),
    .rmwResult(rmwResult), .memAddr(memAddr), .memWrData(memWrData), .m1(m1),
    .rdStb(rdStb), .wrStb(wrStb), .rfshStb(rfshStb), .tState(tState),
    .rfshAddr(rfshAddr), .opcode(opcode), .operand(operand), .done(done)
  );

  mcycle_seq #(.RFSH_INIT(8'hFE)) dutHi_i (
    .clk(clk), .rstN(rstN), .memData(memData), .ixVal(ixVal), .iyVal(iyVal),
    .rmwResult(rmwResult), .memAddr(hiAddr), .memWrData(hiWrData), .m1(hiM1),
    .rdStb(hiRd), .wrStb(hiWr), .rfshStb(hiRfshStb), .tState(hiT),
    .rfshAddr(hiRfsh), .opcode(hiOpcode), .operand(hiOperand), .done(hiDone)
  );

  // {cycle-length pattern 24, fetch count 4, final opcode 8, indexed address 16}
  localparam int NV = 8;
  localparam logic [51:0] VEC [NV] = '{
    {24'h000004, 4'd1, 8'h00, 16'h0000},  // R2 plain
    {24'h000044, 4'd2, 8'h46, 16'h0000},  // R4 X prefix
    {24'h443543, 4'd3, 8'h06, 16'h0045},  // R5 Y, disp +5
    {24'h443543, 4'd3, 8'h16, 16'h0080},  // R5 X, disp -2
    {24'h000044, 4'd2, 8'h07, 16'h0000},  // R4 bit prefix
    {24'h000044, 4'd2, 8'h44, 16'h0000},  // R4 ext prefix
    {24'h000004, 4'd1, 8'h3E, 16'h0000},  // R2 plain
    {24'h443543, 4'd3, 8'h0E, 16'h0070}   // R7 wrap past 0xFFFF
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic runInstr(input logic [51:0] v);
    logic [23:0] pat = '0;
    int m1n = 0, clocks = 0, cyc = 0;
    logic [15:0] pc0 = memAddr;
    logic [7:0]  r0 = rfshAddr;
    logic [15:0] ea = v[15:0];
    logic [7:0]  pre = mem[v[7:0]];
    while (1) begin
      clocks++;
      if (tState == 3'd1) begin
        cyc++;
        pat = {pat[19:0], 4'd1};
        if (m1) m1n++;
      end else begin
        pat[3:0] = pat[3:0] + 4'd1;
      end
      if (m1 && tState >= 3'd3)
        chk(memAddr == {8'h00, rfshAddr} && rfshStb && !rdStb, "R8 refresh slot", memAddr, {8'h00, rfshAddr});
      if (m1 && tState <= 3'd2)
        chk(rdStb && !rfshStb, "R8 fetch strobes", {rdStb, rfshStb}, 2);
      if (v[27:24] == 4'd3 && cyc == 3 && tState == 3'd1)
        chk(!m1 && rdStb && memAddr == pc0 + 16'd2, "R6 displacement read", memAddr, pc0 + 16'd2);
      if (wrStb && tState == 3'd1) begin
        chk(memAddr == ea, "R7 write address", memAddr, ea);
        chk(memWrData == ~pre, "R7 write data", memWrData, ~pre);
      end
      if (wrStb && tState == 3'd3) mem[memAddr[7:0]] = memWrData;
      if (done) break;
      if (clocks > 40) break;
      @(negedge clk);
    end
    @(negedge clk);
    chk(pat == v[51:28], "R2/R4/R5 cycle lengths", pat, v[51:28]);
    chk(m1n == int'(v[27:24]), "R5 fetch count", m1n, v[27:24]);
    chk(((rfshAddr - r0) & 8'h7F) == {4'd0, v[27:24]}, "R3 refresh steps", (rfshAddr - r0) & 8'h7F, v[27:24]);
    chk(tState == 3'd1 && m1 && !done, "R10 next fetch starts", tState, 1);
    chk(opcode == v[23:16], "R9 final opcode", opcode, v[23:16]);
    if (v[27:24] == 4'd3) begin
      chk(clocks == 23, "R5 total T-states", clocks, 23);
      chk(operand == pre, "R9 operand byte", operand, pre);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    {mem[1], mem[2]} = {8'hDD, 8'h46};
    {mem[3], mem[4], mem[5], mem[6]} = {8'hFD, 8'hCB, 8'h05, 8'h06};
    {mem[7], mem[8], mem[9], mem[10]} = {8'hDD, 8'hCB, 8'hFE, 8'h16};
    {mem[11], mem[12]} = {8'hCB, 8'h07};
    {mem[13], mem[14]} = {8'hED, 8'h44};
    mem[15] = 8'h3E;
    {mem[16], mem[17], mem[18], mem[19]} = {8'hDD, 8'hCB, 8'h78, 8'h0E};
    mem[8'h45] = 8'h5A;
    mem[8'h80] = 8'h3C;

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values, checked before the first active edge
    chk(tState == 3'd1 && m1 && rdStb && !wrStb && !rfshStb && !done, "R1 strobes", {m1, rdStb, wrStb, rfshStb, done}, 5'b11000);
    chk(memAddr == 16'h0000, "R1 address", memAddr, 0);
    chk(rfshAddr == 8'h00 && hiRfsh == 8'hFE, "R1 refresh init", rfshAddr, 0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (i == 7) ixVal = 16'hFFF8;
      runInstr(VEC[i]);
      if (i == 0) chk(hiRfsh == 8'hFF, "R3 high-bit instance", hiRfsh, 8'hFF);
      if (i == 1) chk(hiRfsh == 8'h81, "R3 wrap keeps bit 7", hiRfsh, 8'h81);
    end
    chk(mem[8'h45] == 8'hA5, "R7 memory after +5", mem[8'h45], 8'hA5);
    chk(mem[8'h80] == 8'hC3, "R7 memory after -2", mem[8'h80], 8'hC3);
    chk(mem[8'h70] == 8'hFF, "R7 memory after wrap", mem[8'h70], 8'hFF);

    // R3: 17 fetches so far, 120 more carry the counter past 0x7F
    for (int n = 0; n < 120; n++) runInstr({24'h000004, 4'd1, memData, 16'h0000});
    chk(rfshAddr == 8'h09, "R3 7-bit wrap", rfshAddr, 8'h09);
    chk(hiRfsh == 8'h87, "R3 bit 7 held", hiRfsh, 8'h87);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule